// File: doc/BRIEF.md
# Pin Output and Drive-Enable Register Bank with Atomic Bit Aliases

This block keeps the output level and the drive-enable state for 57 pins in four state words: pins 0 to 31 in a full 32-bit low word, and pins 32 to 56 in a 25-bit high word whose top seven bits do not exist. There is one such pair of words for output levels and one for drive enables. The two state vectors go straight to the pad ring as parallel outputs.

Each state word can be reached at three word addresses. The plain address reads and overwrites the whole word. The set alias turns on every bit written as 1. The clear alias turns off every bit written as 1. In the set and clear aliases, a 0 bit leaves the state as it is. Software can therefore raise or drop one pin in a single bus write, and a concurrent task that owns other pins in the same word is not disturbed. There is no read-modify-write.

The bus is a simple word-addressed register port. A write is accepted in any cycle where the write strobe is high, and it takes effect at that clock edge. Read data is a combinational function of the address and the current state.

Top module: `gpio_bank`

## Requirements
- R1: After reset every output level bit and every drive-enable bit is 0, and every address reads 0.
- R2: A write to a plain address replaces the state word at the clock edge that accepts it. The addresses are: word 0 for output pins 0-31, word 3 for output pins 32-56, word 7 for enable pins 0-31 and word 10 for enable pins 32-56. For a high word only write-data bits 24:0 are kept, and they map to pins 32-56.
- R3: A write to a set alias forces to 1 each state bit whose write-data bit is 1 and leaves the other bits unchanged. The set aliases are words 1, 4, 8 and 11, one address above their plain word.
- R4: A write to a clear alias forces to 0 each state bit whose write-data bit is 1 and leaves the other bits unchanged. The clear aliases are words 2, 5, 9 and 12, two addresses above their plain word.
- R5: A read of a plain address returns the current state word. In a high word, bits 31:25 read 0 whatever was written to them.
- R6: Reads of any set or clear alias, of reserved words 6 and 13, and of words 14 and 15 return 0. Writes to words 6, 13, 14 and 15 change no state.
- R7: Writes to the output-level addresses (words 0-5) leave every drive-enable bit unchanged. Writes to the enable addresses (words 7-12) leave every output-level bit unchanged. A write to a low-word address leaves the matching high word unchanged.
- R8: In a cycle with the write strobe low, all state holds. pad_out[i] and pad_oe[i] always show state bit i: the low word holds pins 0-31 and high-word bit k holds pin 32+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Word address of the access |
| bus_we | input | 1 | Write strobe; a write is accepted in each cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_out | output | 57 | Output level per pin |
| pad_oe | output | 57 | Drive enable per pin |

## Verification
The hardest situation to reach from the ports is an alias write whose data carries ones in positions that must not matter. Examples are all-ones written to a high-word clear or set alias, where bits 31:25 have no storage, and a set alias write that overlaps bits already set. Both leave the pads looking unchanged if the logic is right, and can hide a fault if it is wrong. The stimulus first builds distinct, non-trivial patterns in all four words. It then issues full-width alias writes and reads back every plain word and both pad vectors after each one. This shows that only the selected bits of the selected word moved and that the reserved bits still read 0.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Kind of access a bus address selects.
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_PLAIN = 2'd1,
        ACC_SET   = 2'd2,
        ACC_CLR   = 2'd3
    } acc_kind_e;

    // Words per register group: plain/set/clear for low and high, plus one reserved.
    localparam int GROUP_STRIDE = 7;
    localparam int NUM_GROUPS   = 2;
    localparam int NUM_HALVES   = 2;
    localparam int MAPPED_WORDS = GROUP_STRIDE * NUM_GROUPS;

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic              grp,
    output logic              half
);

    int idx;
    int sub;

    always_comb begin
        idx  = int'(addr);
        kind = ACC_NONE;
        grp  = 1'b0;
        half = 1'b0;
        sub  = GROUP_STRIDE - 1;
        if (idx < MAPPED_WORDS) begin
            grp = (idx >= GROUP_STRIDE);
            sub = grp ? (idx - GROUP_STRIDE) : idx;
        end
        case (sub)
            0: begin kind = ACC_PLAIN; half = 1'b0; end
            1: begin kind = ACC_SET;   half = 1'b0; end
            2: begin kind = ACC_CLR;   half = 1'b0; end
            3: begin kind = ACC_PLAIN; half = 1'b1; end
            4: begin kind = ACC_SET;   half = 1'b1; end
            5: begin kind = ACC_CLR;   half = 1'b1; end
            default: begin kind = ACC_NONE; half = 1'b0; end
        endcase
    end

endmodule

// File: rtl/gpio_bank_word.sv
module gpio_bank_word #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_plain,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] q_next;

    // Clear is applied last, so it dominates any set of the same bit.
    always_comb begin
        q_next = wr_plain ? wdata : q;
        if (wr_set) q_next = q_next | wdata;
        if (wr_clr) q_next = q_next & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

    AST_PLAIN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_plain && !wr_set && !wr_clr) |=> (q == $past(wdata))); // R2

    AST_SET_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && !wr_plain && !wr_clr) |=> ((q & $past(q)) == $past(q))); // R3

    AST_CLR_ADDS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !wr_plain && !wr_set) |=> ((q & ~$past(q)) == '0)); // R4

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 57,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);

    localparam int LO_W = DATA_W;
    localparam int HI_W = NUM_PINS - DATA_W;

    acc_kind_e acc_kind;
    logic      acc_grp;
    logic      acc_half;

    gpio_bank_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .kind (acc_kind),
        .grp  (acc_grp),
        .half (acc_half)
    );

    // word_q[group][half], zero-extended to the bus width.
    logic [DATA_W-1:0] word_q [NUM_GROUPS][NUM_HALVES];

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
        for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
            localparam int W = (h == 0) ? LO_W : HI_W;
            logic         hit;
            logic [W-1:0] q;
            logic [DATA_W-1:0] ext;

            assign hit = bus_we && (acc_grp == g[0]) && (acc_half == h[0]);

            gpio_bank_word #(.W(W)) u_word (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_plain (hit && (acc_kind == ACC_PLAIN)),
                .wr_set   (hit && (acc_kind == ACC_SET)),
                .wr_clr   (hit && (acc_kind == ACC_CLR)),
                .wdata    (bus_wdata[W-1:0]),
                .q        (q)
            );

            always_comb begin
                ext        = '0;
                ext[W-1:0] = q;
            end
            assign word_q[g][h] = ext;
        end
    end

    assign pad_out = {word_q[0][1][HI_W-1:0], word_q[0][0]};
    assign pad_oe  = {word_q[1][1][HI_W-1:0], word_q[1][0]};

    always_comb begin
        bus_rdata = '0;
        if (acc_kind == ACC_PLAIN) bus_rdata = word_q[acc_grp][acc_half];
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pad_out) && $stable(pad_oe))); // R8

    AST_SET_NEVER_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && acc_kind == ACC_SET) |=>
        ((($past(pad_out) & ~pad_out) == '0) && (($past(pad_oe) & ~pad_oe) == '0))); // R3

    AST_CLR_NEVER_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && acc_kind == ACC_CLR) |=>
        (((pad_out & ~$past(pad_out)) == '0) && ((pad_oe & ~$past(pad_oe)) == '0))); // R4

    AST_ALIAS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind != ACC_PLAIN) |-> (bus_rdata == '0)); // R6

    AST_HIGH_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == ACC_PLAIN && acc_half) |-> (bus_rdata[DATA_W-1:HI_W] == '0)); // R5

    AST_OUT_SPARES_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !acc_grp) |=> $stable(pad_oe)); // R7

    AST_OE_SPARES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && acc_grp) |=> $stable(pad_out)); // R7

    AST_DEAD_WORD_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && acc_kind == ACC_NONE) |=> ($stable(pad_out) && $stable(pad_oe))); // R6

endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [56:0] pad_out;
    logic [56:0] pad_oe;

    logic [56:0] exp_out = '0;
    logic [56:0] exp_oe  = '0;
    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    gpio_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input int a);
        case (a)
            0:  return exp_out[31:0];
            3:  return {7'b0, exp_out[56:32]};
            7:  return exp_oe[31:0];
            10: return {7'b0, exp_oe[56:32]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(input int a, input logic [31:0] d);
        case (a)
            0:  exp_out[31:0]  = d;
            1:  exp_out[31:0]  = exp_out[31:0] | d;
            2:  exp_out[31:0]  = exp_out[31:0] & ~d;
            3:  exp_out[56:32] = d[24:0];
            4:  exp_out[56:32] = exp_out[56:32] | d[24:0];
            5:  exp_out[56:32] = exp_out[56:32] & ~d[24:0];
            7:  exp_oe[31:0]   = d;
            8:  exp_oe[31:0]   = exp_oe[31:0] | d;
            9:  exp_oe[31:0]   = exp_oe[31:0] & ~d;
            10: exp_oe[56:32]  = d[24:0];
            11: exp_oe[56:32]  = exp_oe[56:32] | d[24:0];
            12: exp_oe[56:32]  = exp_oe[56:32] & ~d[24:0];
            default: ;
        endcase
    endtask

    // Write at a falling edge; the state changes at the next rising edge.
    task automatic bus_write(input int a, input logic [31:0] d, input string tag);
        @(negedge clk);
        bus_addr  = 4'(a);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        model_write(a, d);
        chk({tag, " pad_out"}, {7'b0, pad_out}, {7'b0, exp_out});
        chk({tag, " pad_oe"},  {7'b0, pad_oe},  {7'b0, exp_oe});
    endtask

    task automatic read_chk(input int a, input string tag);
        bus_addr = 4'(a);
        #1;
        chk($sformatf("%s read word %0d", tag, a), {32'b0, bus_rdata}, {32'b0, model_read(a)});
    endtask

    task automatic read_all(input string tag);
        @(negedge clk);
        for (int a = 0; a < 16; a++) read_chk(a, tag);
    endtask

    task automatic t_reset;
        chk("R1 reset pad_out", {7'b0, pad_out}, 64'h0);
        chk("R1 reset pad_oe",  {7'b0, pad_oe},  64'h0);
        read_all("R1");
    endtask

    task automatic t_plain;
        bus_write(0,  32'hA5A5_0F0F, "R2 low out");
        bus_write(3,  32'hFFFF_FFFF, "R2 high out");
        bus_write(7,  32'h1234_5678, "R2 low oe");
        bus_write(10, 32'h0155_AA33, "R2 high oe");
        read_all("R5 plain");
        chk("R8 pin 56 level", {63'b0, pad_out[56]}, 64'h1);
        chk("R8 pin 32 enable", {63'b0, pad_oe[32]}, 64'h1);
    endtask

    task automatic t_set;
        bus_write(1,  32'h0000_00F0, "R3 low out set");
        bus_write(11, 32'hFFFF_FFFF, "R3 high oe set full");
        bus_write(8,  32'h0000_0000, "R3 zero set");
        bus_write(4,  32'h0000_0001, "R3 high out set overlap");
        read_all("R3");
    endtask

    task automatic t_clear;
        bus_write(2,  32'h8000_0001, "R4 low out clear");
        bus_write(5,  32'hFFFF_FFFF, "R4 high out clear full");
        bus_write(9,  32'h0000_0000, "R4 zero clear");
        bus_write(12, 32'h0100_0000, "R4 high oe clear top pin");
        read_all("R4");
    endtask

    task automatic t_dead_words;
        bus_write(6,  32'hFFFF_FFFF, "R6 reserved 6");
        bus_write(13, 32'hFFFF_FFFF, "R6 reserved 13");
        bus_write(14, 32'hFFFF_FFFF, "R6 unmapped 14");
        bus_write(15, 32'hFFFF_FFFF, "R6 unmapped 15");
        read_all("R6");
    endtask

    task automatic t_independent;
        bus_write(0,  32'h0000_0000, "R7 out low to zero");
        bus_write(1,  32'hFFFF_FFFF, "R7 out low set leaves high");
        bus_write(9,  32'hFFFF_FFFF, "R7 oe low clear leaves out");
        bus_write(10, 32'h0000_0000, "R7 oe high zero");
        read_all("R7");
    endtask

    task automatic t_hold;
        logic [56:0] o, e;
        @(negedge clk);
        bus_addr  = 4'd0;
        bus_wdata = 32'hDEAD_BEEF;
        o = pad_out;
        e = pad_oe;
        repeat (5) @(negedge clk);
        chk("R8 hold out", {7'b0, pad_out}, {7'b0, o});
        chk("R8 hold oe",  {7'b0, pad_oe},  {7'b0, e});
    endtask

    initial begin
        #(200000 * 8);
        n_fails++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_plain;
        t_set;
        t_clear;
        t_dead_words;
        t_independent;
        t_hold;
        @(negedge clk);
        rst_n = 1'b0;
        exp_out = '0;
        exp_oe  = '0;
        #1;
        t_reset;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule